// File: doc/BRIEF.md
# Four-mode SPI master with per-slave select

This block is a synchronous serial master that swaps one byte in each direction with one of several attached slaves. A client presents a byte to send, the index of the target slave, the clock polarity and phase bits and a half-period divider, then pulses a start strobe. The master pulls only that slave's active-low select line, produces eight serial clock periods from the system clock, shifts the byte out most significant bit first on the data-out line, and gathers the slave's reply from the data-in line.

When the exchange finishes, the received byte appears on `rx_byte` together with a one-cycle `done` pulse. Transfers can run back to back by issuing a new start after each done. The mode and divider are sampled when the start strobe is taken, so they may be changed between transfers.

Top module: `spi_mode_master`

## Requirements
- R1: After reset every select line is high, `sclk` is low, `done` and `busy` are low.
- R2: Between transfers `sclk` rests at the level of `cpol` (0 low, 1 high).
- R3: Each transfer makes exactly 16 `sclk` transitions (8 full periods), spaced `H` system clocks apart, where H is `half_div`, or 1 when `half_div` is 0.
- R4: The bits on `mosi`, taken at the slave's capture edges, are `tx_byte` most significant bit first. The capture edge is the edge leaving the idle level when `cpha`=0 (mode 0 rising, mode 2 falling) and the edge returning to it when `cpha`=1 (mode 1 falling, mode 3 rising). Data changes on the other edge.
- R5: The master captures `miso` on the same capture edges, and `rx_byte` holds the eight captured bits, first bit in bit 7.
- R6: During a transfer only `cs_n[slave_sel]` is low, all other select lines stay high, and the selection does not change until the transfer ends.
- R7: With `cpha`=0 the most significant bit of `tx_byte` is already on `mosi` in the cycle the select line falls.
- R8: The select line falls H system clocks before the first `sclk` transition and rises H system clocks after the last one.
- R9: `done` is high for exactly one system clock, in the cycle the select line is back high and `busy` has fallen, with `rx_byte` valid from then on.
- R10: A start strobe while `busy` is high is ignored: the running transfer keeps its data and slave, and only one `done` follows.
- R11: A `half_div` of 0 behaves as a divider of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| half_div | input | DIV_W | System clocks per half `sclk` period |
| slave_sel | input | SEL_W | Index of the slave to address |
| tx_byte | input | DATA_W | Byte to send |
| miso | input | 1 | Serial data from the slaves |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slaves |
| cs_n | output | NUM_SLAVES | Active-low select, one per slave |
| rx_byte | output | DATA_W | Byte received in the last transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest case to reach is a start strobe arriving while a transfer is half done with a different slave index and byte, since a correct master never lets it through and nothing at the ports shows it was seen. The bench drives such a strobe in the middle of a transfer, then checks that the slave model received the original byte, that the select pattern never moved, and that exactly one done pulse arrived. The bench also runs a slave model that works out capture and launch edges from the polarity it was told, so each of the four modes is checked against the mode rules rather than against the master's own edge choice.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_TRAIL = 2'd2
  } xfer_state_t;

  // Divider of zero is treated as one half-period of one system clock.
  function automatic logic [15:0] eff_half(input logic [15:0] div);
    return (div == 16'd0) ? 16'd1 : div;
  endfunction

  // Edge index LSB: 0 = leading edge, 1 = trailing edge.
  function automatic logic is_capture(input logic cpha, input logic edge_lsb);
    return edge_lsb == cpha;
  endfunction

  // Launch edges move data; with cpha=1 the very first leading edge keeps the
  // preloaded MSB in place.
  function automatic logic is_launch(input logic cpha, input logic edge_lsb,
                                     input logic first_edge);
    return cpha ? (!edge_lsb && !first_edge) : edge_lsb;
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_len - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DIV_W'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half_len > DIV_W'(1)) |=> !tick); // R8

endmodule

// File: rtl/spi_shift_pair.sv
module spi_shift_pair #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              launch,
  input  logic              capture,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_val
);
  logic [DATA_W-1:0] tx_sh;

  assign mosi = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      rx_val <= '0;
    end else begin
      if (load)        tx_sh <= load_val;
      else if (launch) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      if (capture)     rx_val <= {rx_val[DATA_W-2:0], miso};
    end
  end

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && capture)); // R4

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(launch || capture)); // R10

endmodule

// File: rtl/spi_sel_decode.sv
module spi_sel_decode #(
  parameter int NUM_SLAVES = 4,
  parameter int SEL_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set,
  input  logic                  clr,
  input  logic [SEL_W-1:0]      sel,
  output logic [NUM_SLAVES-1:0] cs_n
);
  for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cs_n[i] <= 1'b1;
      else if (set) cs_n[i] <= (sel != SEL_W'(i));
      else if (clr) cs_n[i] <= 1'b1;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1); // R6

endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master #(
  parameter int NUM_SLAVES = 4,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int SEL_W      = (NUM_SLAVES > 1) ? $clog2(NUM_SLAVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic [DIV_W-1:0]      half_div,
  input  logic [SEL_W-1:0]      slave_sel,
  input  logic [DATA_W-1:0]     tx_byte,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic [NUM_SLAVES-1:0] cs_n,
  output logic [DATA_W-1:0]     rx_byte,
  output logic                  busy,
  output logic                  done
);
  import spi_mode_pkg::*;

  localparam int NUM_EDGES = 2 * DATA_W;
  localparam int EDGE_W    = $clog2(NUM_EDGES + 1);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(NUM_EDGES - 1);

  xfer_state_t       state;
  logic              cpol_q, cpha_q, phase;
  logic [SEL_W-1:0]  sel_q;
  logic [DIV_W-1:0]  half_q;
  logic [EDGE_W-1:0] edge_cnt;
  logic [DATA_W-1:0] rx_val;

  // Named internal events
  logic tick, accept, edge_ev, launch_ev, capture_ev, finish_ev;

  assign busy       = (state != ST_IDLE);
  assign accept     = (state == ST_IDLE) && start;
  assign edge_ev    = (state == ST_RUN) && tick;
  assign launch_ev  = edge_ev && is_launch(cpha_q, edge_cnt[0], edge_cnt == '0);
  assign capture_ev = edge_ev && is_capture(cpha_q, edge_cnt[0]);
  assign finish_ev  = (state == ST_TRAIL) && tick;
  assign sclk       = cpol_q ^ phase;

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_len(half_q), .tick(tick)
  );

  spi_shift_pair #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(tx_byte),
    .launch(launch_ev), .capture(capture_ev), .miso(miso),
    .mosi(mosi), .rx_val(rx_val)
  );

  spi_sel_decode #(.NUM_SLAVES(NUM_SLAVES), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .set(accept), .clr(finish_ev),
    .sel(slave_sel), .cs_n(cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      phase    <= 1'b0;
      sel_q    <= '0;
      half_q   <= DIV_W'(1);
      edge_cnt <= '0;
      rx_byte  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cpol_q <= cpol;
          if (start) begin
            cpha_q   <= cpha;
            sel_q    <= slave_sel;
            half_q   <= DIV_W'(eff_half(16'(half_div)));
            edge_cnt <= '0;
            phase    <= 1'b0;
            state    <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick) begin
            phase    <= ~phase;
            edge_cnt <= edge_cnt + EDGE_W'(1);
            if (edge_cnt == LAST_EDGE) state <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            rx_byte <= rx_val;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol_q)); // R2

  AST_EDGE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRAIL) |-> (edge_cnt == EDGE_W'(NUM_EDGES))); // R3

  AST_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cs_n[sel_q] == 1'b0)); // R6

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && (&cs_n))); // R9

  AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mosi == $past(tx_byte[DATA_W-1]))); // R7

endmodule

// File: tb/spi_mode_master_tb_top.sv
module spi_mode_master_tb_top;
  localparam int NS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [7:0] half_div = 8'd1;
  logic [1:0] slave_sel = '0;
  logic [7:0] tx_byte = '0;
  logic       miso = 1'b0;
  logic       sclk, mosi, busy, done;
  logic [NS-1:0] cs_n;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0;

  always #2 clk = ~clk; // 250 MHz

  spi_mode_master #(.NUM_SLAVES(NS), .DATA_W(8), .DIV_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
    .half_div(half_div), .slave_sel(slave_sel), .tx_byte(tx_byte),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .rx_byte(rx_byte), .busy(busy), .done(done)
  );

  // Slave model and timing monitor
  logic       m_cpol = 0, m_cpha = 0;
  logic [7:0] s_tx = '0, s_rx = '0;
  int         s_idx = 0;
  logic       in_xfer = 0, prev_sclk = 0, prev_done = 0, mosi_at_fall = 0;
  logic       cs_changed = 0, done_wide = 0;
  logic [NS-1:0] cs_seen = '1;
  int cyc = 0, edges = 0, first_at = 0, last_at = 0, rise_at = 0, done_cnt = 0;

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (done && prev_done) done_wide = 1;
    prev_done = done;
    if (in_xfer) cyc++;
    if (!in_xfer && cs_n != '1) begin
      in_xfer = 1; cyc = 0; edges = 0; cs_seen = cs_n; cs_changed = 0;
      mosi_at_fall = mosi; s_rx = '0; s_idx = 0;
      if (!m_cpha) begin miso = s_tx[7]; s_idx = 1; end
    end else if (in_xfer && cs_n == '1) begin
      in_xfer = 0; rise_at = cyc;
    end else if (in_xfer) begin
      if (cs_n != cs_seen) cs_changed = 1;
      if (sclk != prev_sclk) begin
        edges++;
        if (edges == 1) first_at = cyc;
        last_at = cyc;
        // leading edge leaves the idle level
        if ((sclk != m_cpol) == !m_cpha) s_rx = {s_rx[6:0], mosi};
        else if (s_idx < 8) begin miso = s_tx[7 - s_idx]; s_idx++; end
      end
    end
    prev_sclk = sclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [1:0] sel, input logic [7:0] tb, input logic [7:0] sb,
                          input logic pol, input logic pha, input logic [7:0] hd,
                          input bit poke);
    int eh = (hd == 0) ? 1 : int'(hd);
    int d0 = done_cnt;
    @(negedge clk);
    m_cpol = pol; m_cpha = pha; s_tx = sb;
    cpol = pol; cpha = pha; half_div = hd; slave_sel = sel; tx_byte = tb;
    repeat (2) @(negedge clk);
    check(sclk == pol, "R2 idle level before", sclk, pol);
    start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (5 * eh) @(negedge clk);
      slave_sel = sel + 2'd1; tx_byte = ~tb; cpha = ~pha; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    check(rx_byte == sb, "R5 rx byte", rx_byte, sb);
    check(s_rx == tb, "R4 mosi byte at slave", s_rx, tb);
    check(edges == 16, "R3 edge count", edges, 16);
    check(first_at == eh, "R8 cs setup", first_at, eh);
    check(rise_at - last_at == eh, "R8 cs hold", rise_at - last_at, eh);
    check(last_at - first_at == 15 * eh, "R3 edge spacing", last_at - first_at, 15 * eh);
    check(cs_seen == ~(4'b1 << sel) && !cs_changed, "R6 select", cs_seen, ~(4'b1 << sel));
    if (!pha) check(mosi_at_fall == tb[7], "R7 first bit at cs fall", mosi_at_fall, tb[7]);
    check(done_cnt - d0 == 1 && !done_wide, "R9 single done", done_cnt - d0, 1);
    check(!busy && cs_n == '1 && sclk == pol, "R2 idle after", {busy, cs_n, sclk}, {1'b0, 4'hF, pol});
  endtask

  task automatic reset_test();
    repeat (3) @(negedge clk);
    check(cs_n == '1 && sclk == 0 && !done && !busy, "R1 reset state",
          {cs_n, sclk, done, busy}, {4'hF, 3'b000});
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic poke_test();
    int d0 = done_cnt;
    run_xfer(2'd1, 8'h96, 8'h0F, 1'b0, 1'b0, 8'd3, 1'b1);
    repeat (4) @(negedge clk);
    check(done_cnt - d0 == 1 && !busy, "R10 busy start ignored", done_cnt - d0, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reset_test();
    run_xfer(2'd0, 8'hA5, 8'h3C, 1'b0, 1'b0, 8'd2, 1'b0); // mode 0
    run_xfer(2'd1, 8'h5A, 8'hC3, 1'b0, 1'b1, 8'd3, 1'b0); // mode 1
    run_xfer(2'd2, 8'h81, 8'h7E, 1'b1, 1'b0, 8'd1, 1'b0); // mode 2
    run_xfer(2'd3, 8'hF0, 8'h01, 1'b1, 1'b1, 8'd4, 1'b0); // mode 3
    run_xfer(2'd3, 8'h00, 8'hFF, 1'b0, 1'b0, 8'd0, 1'b0); // R11 divider 0
    run_xfer(2'd0, 8'hFF, 8'h00, 1'b1, 1'b1, 8'd0, 1'b0); // R11 divider 0, mode 3
    poke_test();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule